// File: doc/BRIEF.md
# Configurable Parallel Pin-Bus Transaction Engine

This block is a host-side master for a 32-bit parallel pin bus that talks to programmable-logic peripherals. The host hands it one request at a time over a valid/ready channel: an address, write data and a read/write flag. The engine turns each request into a short bus transaction. It packs data, address and control onto the pins, drives an output enable for every pin, and returns read data on a response channel with a one-cycle valid pulse.

Static configuration inputs set the shape of the bus: how wide the data field is, how wide the address field is, whether a clock pin is driven, and whether that clock is gated or free-running. They also enable the write strobe and the frame pin, and pick one-cycle or two-cycle writes. Reads always take two phases. In the request phase RD is high and the address is driven. The capture phase follows with RD low. A ready input from the peripheral holds the current phase for as long as it stays low. Combinations that the pin map cannot carry raise an error flag. While that flag is high, requests are consumed without any bus activity.

Top module: `pbus_txn_engine`

## Requirements
- R1: The data field sits at pin bits [7:0], [15:0], [23:0] or [31:0] for width codes 0, 1, 2, 3. Write data drives it and its output enables are high only in the write data phase. Read data is captured from the same bits and zero-extended.
- R2: Address width codes 0, 1, 2, 3 select no address, 4 bits at pins [27:24], 12 bits at [27:16] or 20 bits at [27:8]. The field carries the host address shifted right by 1 when the data width code is 1, by 2 when it is 2, and by 0 otherwise. Its output enables stay high whenever an address width is in use, and it drives zero outside a transaction.
- R3: In non-32-bit modes, WR is on pin 28, RD on pin 29, frame on pin 30 and clock on pin 31. RD is always owned. WR is owned only when the strobe enable or two-cycle writes are on. WR and RD are never high together.
- R4: The configuration is illegal when the 32-bit data width (code 3) is combined with any address, clock, strobe, frame or two-cycle write; when 24-bit data is combined with a 12- or 20-bit address; or when 16-bit data is combined with a 20-bit address. An illegal configuration raises cfg_err, keeps every pin low with its enable off, and consumes requests with no transaction and no response.
- R5: A read spends one phase with RD high and the address driven, then one phase with RD low and the data lines undriven. Pin data is captured at the end of that second phase, and rsp_valid pulses for one cycle in the following cycle.
- R6: With two-cycle writes off, a write is a single phase in which WR, the address and the data are driven together.
- R7: With two-cycle writes on, a write drives WR and the address with the data lines undriven, then drives the data with WR low. WR is owned even when the strobe enable is off.
- R8: While ext_ready is low, the current phase and every pin value are held and req_ready stays low.
- R9: With the gated clock selected, the clock pin is high outside the request phase and low throughout the request phase.
- R10: With the free-running clock selected, the clock pin toggles every cycle.
- R11: When frame is enabled, the frame pin is high exactly during the request phase.
- R12: After reset the engine is idle with req_ready high and rsp_valid low. Every pin whose enable is off is driven low.
- R13: In 32-bit mode no control pins are used. A write drives all 32 pins with data, and a read captures all 32 pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dsize | input | 2 | Data width code: 0=8, 1=16, 2=24, 3=32 bits |
| cfg_asize | input | 2 | Address width code: 0=none, 1=4, 2=12, 3=20 bits |
| cfg_clk_en | input | 1 | Drive the clock pin |
| cfg_clk_gate | input | 1 | 1 = gated clock, 0 = free-running |
| cfg_strobe_en | input | 1 | Use the WR strobe |
| cfg_wr2cyc | input | 1 | Split writes into address and data phases |
| cfg_frame_en | input | 1 | Drive the frame pin |
| cfg_err | output | 1 | Configuration is illegal |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Captured read data |
| ext_ready | input | 1 | Peripheral ready; low stretches the phase |
| pin_in | input | 32 | Pin input values |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |

## Verification
Several behaviours are checked on every cycle by the assertions. Undriven pins must read low, and WR and RD must never be high together. The gated clock must stay high while the engine is idle, and the free-running clock must toggle. An illegal configuration must keep the engine idle, a low ready must freeze the phase and the latched request, and a response may only follow a completed read capture phase. Other behaviours can only be shown by the bench's directed scenarios, because they depend on the chosen widths and on host values. These are the exact pin images in each phase, the address scaling per data width, the zero-extension of captured data, the forced WR under two-cycle writes, and the absence of responses after a rejected request.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int PIN_W     = 32;
    localparam int CTRL_BASE = 28;
    localparam int N_CTRL    = 4;
    localparam int ADDR_TOP  = 28;
    localparam int CI_WR     = 0;
    localparam int CI_RD     = 1;
    localparam int CI_FRAME  = 2;
    localparam int CI_CLK    = 3;

    typedef enum logic [1:0] {DW_8, DW_16, DW_24, DW_32} dwidth_e;
    typedef enum logic [1:0] {AW_NONE, AW_4, AW_12, AW_20} awidth_e;
    typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_DATA} phase_e;

    typedef struct packed {
        dwidth_e dsize;
        awidth_e asize;
        logic    clk_en;
        logic    clk_gate;
        logic    strobe_en;
        logic    wr2cyc;
        logic    frame_en;
    } bus_cfg_t;

    typedef struct packed {
        logic             ok;
        logic             wr_pin;
        logic             rd_pin;
        logic             frame_pin;
        logic             clk_pin;
        logic             gated;
        logic             wr2cyc;
        logic [PIN_W-1:0] dmask;
        logic [PIN_W-1:0] amask;
    } bus_dec_t;

    typedef struct packed {
        logic             wr;
        logic [PIN_W-1:0] addr;
        logic [PIN_W-1:0] wdata;
    } txn_t;

    function automatic logic [PIN_W-1:0] data_mask(dwidth_e d);
        case (d)
            DW_8:    return 32'h0000_00FF;
            DW_16:   return 32'h0000_FFFF;
            DW_24:   return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int addr_bits(awidth_e a);
        case (a)
            AW_4:    return 4;
            AW_12:   return 12;
            AW_20:   return 20;
            default: return 0;
        endcase
    endfunction

    function automatic logic [PIN_W-1:0] addr_mask(awidth_e a);
        case (a)
            AW_4:    return 32'h0F00_0000;
            AW_12:   return 32'h0FFF_0000;
            AW_20:   return 32'h0FFF_FF00;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic int addr_shift(dwidth_e d);
        case (d)
            DW_16:   return 1;
            DW_24:   return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [PIN_W-1:0] addr_field(logic [PIN_W-1:0] host_addr,
                                                    dwidth_e d, awidth_e a);
        logic [PIN_W-1:0] scaled;
        scaled = host_addr >> addr_shift(d);
        return (scaled << (ADDR_TOP - addr_bits(a))) & addr_mask(a);
    endfunction

    function automatic logic cfg_legal(bus_cfg_t c);
        case (c.dsize)
            DW_32:   return (c.asize == AW_NONE) && !c.clk_en && !c.strobe_en
                            && !c.wr2cyc && !c.frame_en;
            DW_24:   return (c.asize == AW_NONE) || (c.asize == AW_4);
            DW_16:   return c.asize != AW_20;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pbus_cfg_decode.sv
module pbus_cfg_decode
    import pbus_pkg::*;
(
    input  bus_cfg_t cfg,
    output bus_dec_t dec
);
    logic legal;
    logic ctrl_ok;

    always_comb begin
        legal         = cfg_legal(cfg);
        ctrl_ok       = legal && (cfg.dsize != DW_32);
        dec.ok        = legal;
        dec.rd_pin    = ctrl_ok;
        dec.wr_pin    = ctrl_ok && (cfg.strobe_en || cfg.wr2cyc);
        dec.frame_pin = ctrl_ok && cfg.frame_en;
        dec.clk_pin   = ctrl_ok && cfg.clk_en;
        dec.gated     = cfg.clk_gate;
        dec.wr2cyc    = legal && cfg.wr2cyc;
        dec.dmask     = legal ? data_mask(cfg.dsize) : '0;
        dec.amask     = legal ? addr_mask(cfg.asize) : '0;
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_ok,
    input  logic             wr2cyc,
    input  logic [PIN_W-1:0] dmask,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [PIN_W-1:0] req_addr,
    input  logic [PIN_W-1:0] req_wdata,
    output logic             req_ready,
    input  logic             ext_ready,
    input  logic [PIN_W-1:0] pin_in,
    output logic             rsp_valid,
    output logic [PIN_W-1:0] rsp_rdata,
    output phase_e           phase,
    output txn_t             txn,
    output logic             clk_tgl
);
    logic split;

    assign split     = !txn.wr || wr2cyc;
    assign req_ready = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            txn       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            clk_tgl   <= 1'b0;
        end else begin
            clk_tgl   <= ~clk_tgl;
            rsp_valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid && cfg_ok) begin
                        txn.wr    <= req_write;
                        txn.addr  <= req_addr;
                        txn.wdata <= req_wdata;
                        phase     <= PH_REQ;
                    end
                end
                PH_REQ: begin
                    if (ext_ready) phase <= split ? PH_DATA : PH_IDLE;
                end
                PH_DATA: begin
                    if (ext_ready) begin
                        phase <= PH_IDLE;
                        if (!txn.wr) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= pin_in & dmask;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8: a low ready freezes the phase and the latched request
    a_r8_stretch_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !ext_ready) |=> (phase == $past(phase) && txn == $past(txn)));

    // R5: a response only follows a completed read capture phase
    a_r5_rsp_source: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(phase) == PH_DATA && $past(ext_ready) && !$past(txn.wr)));

    // R5: a read always moves on to a capture phase
    a_r5_read_split: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REQ && !txn.wr && ext_ready) |=> (phase == PH_DATA));
endmodule

// File: rtl/pbus_pin_pack.sv
module pbus_pin_pack
    import pbus_pkg::*;
(
    input  bus_dec_t         dec,
    input  dwidth_e          dsize,
    input  awidth_e          asize,
    input  phase_e           phase,
    input  txn_t             txn,
    input  logic             clk_tgl,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);
    logic             active;
    logic             in_req;
    logic             data_phase;
    logic [PIN_W-1:0] body_out;
    logic [PIN_W-1:0] body_oe;
    logic [N_CTRL-1:0] ctrl_use;
    logic [N_CTRL-1:0] ctrl_val;

    always_comb begin
        active     = (phase != PH_IDLE);
        in_req     = (phase == PH_REQ);
        data_phase = txn.wr && ((in_req && !dec.wr2cyc) || (phase == PH_DATA && dec.wr2cyc));
        body_out   = (data_phase ? (txn.wdata & dec.dmask) : '0)
                   | (active ? (addr_field(txn.addr, dsize, asize) & dec.amask) : '0);
        body_oe    = (data_phase ? dec.dmask : '0) | dec.amask;

        ctrl_use[CI_WR]    = dec.wr_pin;
        ctrl_use[CI_RD]    = dec.rd_pin;
        ctrl_use[CI_FRAME] = dec.frame_pin;
        ctrl_use[CI_CLK]   = dec.clk_pin;
        ctrl_val[CI_WR]    = in_req && txn.wr;
        ctrl_val[CI_RD]    = in_req && !txn.wr;
        ctrl_val[CI_FRAME] = in_req;
        ctrl_val[CI_CLK]   = dec.gated ? !in_req : clk_tgl;
    end

    assign pin_out[CTRL_BASE-1:0] = body_out[CTRL_BASE-1:0];
    assign pin_oe[CTRL_BASE-1:0]  = body_oe[CTRL_BASE-1:0];

    for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
        assign pin_out[CTRL_BASE+i] = ctrl_use[i] ? ctrl_val[i] : body_out[CTRL_BASE+i];
        assign pin_oe[CTRL_BASE+i]  = ctrl_use[i] ? 1'b1        : body_oe[CTRL_BASE+i];
    end
endmodule

// File: rtl/pbus_txn_engine.sv
module pbus_txn_engine
    import pbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_dsize,
    input  logic [1:0]  cfg_asize,
    input  logic        cfg_clk_en,
    input  logic        cfg_clk_gate,
    input  logic        cfg_strobe_en,
    input  logic        cfg_wr2cyc,
    input  logic        cfg_frame_en,
    output logic        cfg_err,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    input  logic        ext_ready,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe
);
    bus_cfg_t cfg;
    bus_dec_t dec;
    phase_e   phase;
    txn_t     txn;
    logic     clk_tgl;
    logic     free_mode;

    always_comb begin
        cfg.dsize     = dwidth_e'(cfg_dsize);
        cfg.asize     = awidth_e'(cfg_asize);
        cfg.clk_en    = cfg_clk_en;
        cfg.clk_gate  = cfg_clk_gate;
        cfg.strobe_en = cfg_strobe_en;
        cfg.wr2cyc    = cfg_wr2cyc;
        cfg.frame_en  = cfg_frame_en;
    end

    assign cfg_err   = !dec.ok;
    assign free_mode = dec.clk_pin && !dec.gated;

    pbus_cfg_decode u_dec (
        .cfg (cfg),
        .dec (dec)
    );

    pbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_ok    (dec.ok),
        .wr2cyc    (dec.wr2cyc),
        .dmask     (dec.dmask),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .ext_ready (ext_ready),
        .pin_in    (pin_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .phase     (phase),
        .txn       (txn),
        .clk_tgl   (clk_tgl)
    );

    pbus_pin_pack u_pack (
        .dec     (dec),
        .dsize   (cfg.dsize),
        .asize   (cfg.asize),
        .phase   (phase),
        .txn     (txn),
        .clk_tgl (clk_tgl),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R12: a pin that is not enabled is driven low
    a_r12_undriven_low: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    // R3: the two strobes never fire together
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        (dec.wr_pin && dec.rd_pin) |-> !(pin_out[CTRL_BASE+CI_WR] && pin_out[CTRL_BASE+CI_RD]));

    // R9: gated clock rests high while idle
    a_r9_gated_idle_high: assert property (@(posedge clk) disable iff (rst)
        (dec.clk_pin && dec.gated && phase == PH_IDLE) |-> pin_out[CTRL_BASE+CI_CLK]);

    // R10: free-running clock changes every cycle
    a_r10_free_toggle: assert property (@(posedge clk) disable iff (rst)
        (free_mode && $past(free_mode)) |-> (pin_out[CTRL_BASE+CI_CLK] != $past(pin_out[CTRL_BASE+CI_CLK])));

    // R4: an illegal setting never starts a transaction
    a_r4_err_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && phase == PH_IDLE) |=> (phase == PH_IDLE));
endmodule

// File: tb/pbus_txn_engine_tb_top.sv
`timescale 1ns/1ps
module pbus_txn_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_dsize = '0, cfg_asize = '0;
    logic        cfg_clk_en = 0, cfg_clk_gate = 0, cfg_strobe_en = 0, cfg_wr2cyc = 0, cfg_frame_en = 0;
    logic        cfg_err;
    logic        req_valid = 0, req_ready, req_write = 0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ext_ready = 1'b1;
    logic [31:0] pin_in = '0, pin_out, pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pbus_txn_engine dut_i (
        .clk(clk), .rst(rst),
        .cfg_dsize(cfg_dsize), .cfg_asize(cfg_asize), .cfg_clk_en(cfg_clk_en),
        .cfg_clk_gate(cfg_clk_gate), .cfg_strobe_en(cfg_strobe_en),
        .cfg_wr2cyc(cfg_wr2cyc), .cfg_frame_en(cfg_frame_en), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ext_ready(ext_ready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] d, input logic [1:0] a, input logic ce,
                           input logic cg, input logic se, input logic w2, input logic fe);
        @(negedge clk);
        cfg_dsize = d; cfg_asize = a; cfg_clk_en = ce; cfg_clk_gate = cg;
        cfg_strobe_en = se; cfg_wr2cyc = w2; cfg_frame_en = fe;
    endtask

    // returns at the falling edge inside the first bus phase
    task automatic send(input logic wr, input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset;
        chk("R12 reset req_ready", {31'd0, req_ready}, 32'd1);
        chk("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R12 reset pin_out", pin_out, 32'h0);
        chk("R3 reset pin_oe RD owned", pin_oe, 32'h2000_0000);
    endtask

    task automatic t_write_one_cycle;
        set_cfg(2'd0, 2'd3, 0, 0, 1, 0, 1);
        send(1, 32'h000A_BCDE, 32'h0000_005A);
        chk("R6 R2 R11 write phase pin_out", pin_out, 32'h5ABC_DE5A);
        chk("R1 R3 write phase pin_oe", pin_oe, 32'h7FFF_FFFF);
        @(negedge clk);
        chk("R2 R11 idle pin_out", pin_out, 32'h0);
        chk("R1 idle pin_oe", pin_oe, 32'h7FFF_FF00);
        chk("R6 back to idle", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_read16;
        set_cfg(2'd1, 2'd2, 0, 0, 0, 0, 0);
        send(0, 32'h0000_0246, 32'h0);
        pin_in = 32'hDEAD_BEEF;
        chk("R5 R2 read request pin_out", pin_out, 32'h2123_0000);
        chk("R5 read request pin_oe", pin_oe, 32'h2FFF_0000);
        @(negedge clk);
        chk("R5 capture phase pin_out", pin_out, 32'h0123_0000);
        chk("R5 no early rsp", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R5 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk("R1 R5 rsp_rdata", rsp_rdata, 32'h0000_BEEF);
        @(negedge clk);
        chk("R5 rsp pulse ends", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_write_two_cycle;
        set_cfg(2'd0, 2'd1, 0, 0, 0, 1, 1);
        send(1, 32'h0000_0007, 32'h0000_00C3);
        chk("R7 R11 addr phase pin_out", pin_out, 32'h5700_0000);
        chk("R7 addr phase pin_oe", pin_oe, 32'h7F00_0000);
        @(negedge clk);
        chk("R7 R11 data phase pin_out", pin_out, 32'h0700_00C3);
        chk("R7 data phase pin_oe", pin_oe, 32'h7F00_00FF);
        @(negedge clk);
        chk("R7 idle", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_stretch;
        set_cfg(2'd0, 2'd3, 0, 0, 1, 0, 1);
        ext_ready = 0;
        send(1, 32'h000A_BCDE, 32'h0000_005A);
        for (int i = 0; i < 3; i++) begin
            chk("R8 held pin_out", pin_out, 32'h5ABC_DE5A);
            chk("R8 req_ready low", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
        end
        ext_ready = 1;
        @(negedge clk);
        chk("R8 released to idle", pin_out, 32'h0);
    endtask

    task automatic t_gated_clock;
        set_cfg(2'd0, 2'd0, 1, 1, 1, 0, 0);
        @(negedge clk);
        chk("R9 idle clock high", pin_out, 32'h8000_0000);
        chk("R9 idle pin_oe", pin_oe, 32'hB000_0000);
        send(1, 32'h0, 32'h0000_0011);
        chk("R9 request clock low", pin_out, 32'h1000_0011);
        @(negedge clk);
        chk("R9 after clock high", pin_out, 32'h8000_0000);
    endtask

    task automatic t_free_clock;
        logic a, b, c;
        set_cfg(2'd0, 2'd0, 1, 0, 0, 0, 0);
        @(negedge clk); a = pin_out[31];
        @(negedge clk); b = pin_out[31];
        @(negedge clk); c = pin_out[31];
        chk("R10 toggle 1", {31'd0, a ^ b}, 32'd1);
        chk("R10 toggle 2", {31'd0, b ^ c}, 32'd1);
    endtask

    task automatic t_illegal;
        set_cfg(2'd3, 2'd1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R4 err 32+addr", {31'd0, cfg_err}, 32'd1);
        chk("R4 consumed", {31'd0, req_ready}, 32'd1);
        send(1, 32'hF, 32'hFFFF_FFFF);
        for (int i = 0; i < 3; i++) begin
            chk("R4 pins quiet", pin_out | pin_oe, 32'h0);
            @(negedge clk);
        end
        set_cfg(2'd2, 2'd2, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R4 err 24+12", {31'd0, cfg_err}, 32'd1);
        send(0, 32'h4, 32'h0);
        for (int i = 0; i < 3; i++) begin
            chk("R4 no response", {31'd0, rsp_valid}, 32'd0);
            @(negedge clk);
        end
        set_cfg(2'd1, 2'd3, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R4 err 16+20", {31'd0, cfg_err}, 32'd1);
    endtask

    task automatic t_d24;
        set_cfg(2'd2, 2'd1, 0, 0, 1, 0, 0);
        @(negedge clk);
        chk("R4 24+4 legal", {31'd0, cfg_err}, 32'd0);
        send(1, 32'h0000_0014, 32'hABCD_EF12);
        chk("R1 R2 24-bit write", pin_out, 32'h15CD_EF12);
        @(negedge clk);
    endtask

    task automatic t_d32;
        set_cfg(2'd3, 2'd0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R13 32-bit idle oe", pin_oe, 32'h0);
        send(1, 32'h0, 32'hCAFE_F00D);
        chk("R13 32-bit write pins", pin_out, 32'hCAFE_F00D);
        chk("R13 32-bit write oe", pin_oe, 32'hFFFF_FFFF);
        @(negedge clk);
        send(0, 32'h0, 32'h0);
        pin_in = 32'h1234_5678;
        chk("R13 32-bit read no strobe", pin_out | pin_oe, 32'h0);
        @(negedge clk);
        @(negedge clk);
        chk("R13 32-bit rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk("R13 32-bit rsp_rdata", rsp_rdata, 32'h1234_5678);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_write_one_cycle;
        t_read16;
        t_write_two_cycle;
        t_stretch;
        t_gated_clock;
        t_free_clock;
        t_illegal;
        t_d24;
        t_d32;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule